// File: doc/BRIEF.md
# Segment Buffer Bulk Invalidation Engine

This block keeps a small table of segment translation entries. Each entry has a valid flag, a one-bit class, a tag and a data field. A write port loads entries and a combinational read port returns any entry. Software-visible translation logic around the block uses the read port, and the block itself does no address translation.

The main function is a bulk invalidate command. A start pulse arrives with a 32-bit command word, which carries a 3-bit hint at bits [23:21]. A rule-set select input chooses between the older and the newer architecture behaviour. The command visits the entries one per clock in ascending order and clears valid flags according to the hint. Every accepted command sets a sticky request that asks the surrounding logic to flush the rest of its lookaside state. The request stays set until acknowledged. A one-cycle done pulse marks the end of the command.

The controller is a three-state machine:
- `ST_IDLE` waits for a command.
- `ST_WALK` visits one entry per cycle.
- `ST_WRAP` is the single done cycle.

The transitions are:
- IDLE→WALK on an accepted start whose hint clears entries.
- IDLE→WRAP on an accepted start whose hint clears nothing.
- WALK→WALK while the index is below the last entry.
- WALK→WRAP after the last entry.
- WRAP→IDLE unconditionally.

Top module: `segbuf_sweep`

## Requirements
- R1: Under the older rules, for every hint, and under the newer rules for hints 0, 1, 2 and 6, the command clears the valid flag of every valid entry with index 1 to N-1 and leaves entry 0 valid.
- R2: Under the newer rules, hint 4 clears the valid flag of every entry, entry 0 included.
- R3: Under the newer rules, hint 3 walks entry 0 as well, clears valid entries whose class bit is 1 and keeps valid entries whose class bit is 0.
- R4: Under the newer rules, hint 7 clears no entry, still sets the flush request, and raises done in the cycle after the start.
- R5: Hint 5 under the newer rules behaves like hint 0 and raises `hint_warn` for exactly one cycle, the cycle after the start. Under the older rules no hint raises `hint_warn`.
- R6: Entries that are already invalid stay invalid. A cleared entry keeps its class, tag and data unchanged.
- R7: The hint is taken from `cmd_word[23:21]` (bit 21 is the hint LSB). All other bits of `cmd_word` have no effect.
- R8: Every accepted command sets `flush_req` in the cycle after start. `flush_req` stays high until a cycle with `flush_ack` high and no accepted start. When an ack and an accepted start occur in the same cycle, the flag stays set.
- R9: For a command starting at index F (F=0 for hints 3 and 4 under the newer rules, else F=1), entries are visited one per cycle from F to N-1. `done` is high for one cycle, N-F+1 cycles after the start cycle.
- R10: `busy` is high from the cycle after an accepted start through the done cycle. Start pulses and entry writes presented while busy is high are ignored.
- R11: After reset all valid flags are 0 and `busy`, `done`, `flush_req` and `hint_warn` are 0.
- R12: The read port returns the valid flag, class, tag and data of entry `rd_idx` in the same cycle. A write while idle is visible on the read port in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| new_rules | input | 1 | 1 selects the newer hint rules, 0 the older |
| start | input | 1 | Start pulse for a bulk invalidate command |
| cmd_word | input | 32 | Command word, hint at bits [23:21] |
| flush_ack | input | 1 | Clears the sticky flush request |
| wr_en | input | 1 | Entry write strobe (ignored while busy) |
| wr_idx | input | IDX_W | Entry index to write |
| wr_valid | input | 1 | Valid flag to write |
| wr_class | input | 1 | Class bit to write |
| wr_tag | input | TAG_W | Tag to write |
| wr_data | input | DATA_W | Data to write |
| rd_idx | input | IDX_W | Entry index to read |
| rd_valid | output | 1 | Valid flag of entry rd_idx |
| rd_class | output | 1 | Class bit of entry rd_idx |
| rd_tag | output | TAG_W | Tag of entry rd_idx |
| rd_data | output | DATA_W | Data of entry rd_idx |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| flush_req | output | 1 | Sticky lookaside flush request |
| hint_warn | output | 1 | One-cycle undefined-hint warning |

## Verification
A wrong walk index or a wrong end condition shows up in the cycle of `done`. The cycle of `done` is predicted from the hint and the rule set. A stray entry clear or a missed entry clear appears on the read port as soon as the command ends, because every entry is read back against a model after each command. A decoder that maps a hint to the wrong rule changes which entries survive, or leaves `hint_warn` silent. A leak through the busy lock shows up as an extra done pulse or as a changed tag after the command.

// File: rtl/segbuf_pkg.sv
package segbuf_pkg;

    localparam int HINT_W   = 3;
    localparam int HINT_LSB = 21;
    localparam int CMD_W    = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_WRAP = 2'd2
    } walk_state_e;

    typedef struct packed {
        logic incl_zero;
        logic keep_class0;
        logic skip_all;
        logic undef_hint;
    } hint_rule_t;

endpackage

// File: rtl/segbuf_hint_decode.sv
module segbuf_hint_decode
    import segbuf_pkg::*;
(
    input  logic [HINT_W-1:0] hint,
    input  logic              new_rules,
    output hint_rule_t        rule
);

    always_comb begin
        rule = '0;
        if (new_rules) begin
            unique case (hint)
                3'd3: begin
                    rule.incl_zero   = 1'b1;
                    rule.keep_class0 = 1'b1;
                end
                3'd4: rule.incl_zero  = 1'b1;
                3'd5: rule.undef_hint = 1'b1;
                3'd7: rule.skip_all   = 1'b1;
                default: rule = '0;
            endcase
        end
    end

    always_comb begin
        assert (!(rule.skip_all && rule.incl_zero))
            else $error("AST_RULE_EXCLUSIVE"); // R4
    end

endmodule

// File: rtl/segbuf_store.sv
module segbuf_store #(
    parameter int N      = 8,
    parameter int TAG_W  = 12,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_class,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [IDX_W-1:0]  scan_idx,
    output logic              scan_valid,
    output logic              scan_class,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_class,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data
);

    logic [N-1:0]             valid_vec;
    logic [N-1:0]             class_vec;
    logic [N-1:0][TAG_W-1:0]  tag_vec;
    logic [N-1:0][DATA_W-1:0] data_vec;

    logic wr_ok;
    assign wr_ok = wr_en && !lock;

    for (genvar g = 0; g < N; g++) begin : g_entry
        logic              v_q;
        logic              c_q;
        logic [TAG_W-1:0]  t_q;
        logic [DATA_W-1:0] d_q;
        logic              hit_wr;
        logic              hit_clr;

        assign hit_wr  = wr_ok && (wr_idx == IDX_W'(g));
        assign hit_clr = clr_en && (clr_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                c_q <= 1'b0;
                t_q <= '0;
                d_q <= '0;
            end else if (hit_wr) begin
                v_q <= wr_valid;
                c_q <= wr_class;
                t_q <= wr_tag;
                d_q <= wr_data;
            end else if (hit_clr) begin
                v_q <= 1'b0;
            end
        end

        assign valid_vec[g] = v_q;
        assign class_vec[g] = c_q;
        assign tag_vec[g]   = t_q;
        assign data_vec[g]  = d_q;
    end

    logic scan_in_range;
    logic rd_in_range;
    assign scan_in_range = (int'(scan_idx) < N);
    assign rd_in_range   = (int'(rd_idx) < N);

    always_comb begin
        scan_valid = 1'b0;
        scan_class = 1'b0;
        if (scan_in_range) begin
            scan_valid = valid_vec[scan_idx];
            scan_class = class_vec[scan_idx];
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_class = 1'b0;
        rd_tag   = '0;
        rd_data  = '0;
        if (rd_in_range) begin
            rd_valid = valid_vec[rd_idx];
            rd_class = class_vec[rd_idx];
            rd_tag   = tag_vec[rd_idx];
            rd_data  = data_vec[rd_idx];
        end
    end

    AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(tag_vec) && $stable(data_vec) && $stable(class_vec))) // R6
        else $error("AST_FIELDS_FROZEN");
    AST_CLEAR_TARGET_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> valid_vec[clr_idx]) // R6
        else $error("AST_CLEAR_TARGET_VALID");
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !valid_vec[$past(clr_idx)]) // R1
        else $error("AST_CLEAR_TAKES");
    AST_NO_SET_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ((valid_vec & ~$past(valid_vec)) == '0)) // R10
        else $error("AST_NO_SET_WHILE_LOCKED");

endmodule

// File: rtl/segbuf_walk_fsm.sv
module segbuf_walk_fsm
    import segbuf_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  hint_rule_t       rule,
    input  logic             flush_ack,
    input  logic             scan_valid,
    input  logic             scan_class,
    output logic [IDX_W-1:0] scan_idx,
    output logic             clr_en,
    output logic             busy,
    output logic             done,
    output logic             flush_req,
    output logic             hint_warn
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

    walk_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             keep_c0_q;
    logic             flush_q;
    logic             warn_q;
    logic             start_acc;

    assign start_acc = start && (state_q == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = rule.skip_all ? ST_WRAP : ST_WALK;
            end
            ST_WALK: begin
                if (idx_q == LAST_IDX) state_d = ST_WRAP;
            end
            ST_WRAP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            keep_c0_q <= 1'b0;
            flush_q   <= 1'b0;
            warn_q    <= 1'b0;
        end else begin
            warn_q <= start_acc && rule.undef_hint;
            if (start_acc)      flush_q <= 1'b1;
            else if (flush_ack) flush_q <= 1'b0;
            if (start_acc) begin
                idx_q     <= rule.incl_zero ? '0 : IDX_W'(1);
                keep_c0_q <= rule.keep_class0;
            end else if (state_q == ST_WALK && idx_q != LAST_IDX) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_WRAP);
        scan_idx  = idx_q;
        clr_en    = (state_q == ST_WALK) && scan_valid && (!keep_c0_q || scan_class);
        flush_req = flush_q;
        hint_warn = warn_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) // R9
        else $error("AST_DONE_PULSE");
    AST_WARN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hint_warn |=> !hint_warn) // R5
        else $error("AST_WARN_PULSE");
    AST_SKIP_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (start_acc && rule.skip_all) |=> (done && !clr_en)) // R4
        else $error("AST_SKIP_FAST");
    AST_START_SETS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> flush_req) // R8
        else $error("AST_START_SETS_FLUSH");
    AST_FLUSH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_ack) |=> flush_req) // R8
        else $error("AST_FLUSH_STICKY");
    AST_KEEP_CLASS0: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && keep_c0_q) |-> scan_class) // R3
        else $error("AST_KEEP_CLASS0");
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> busy) // R10
        else $error("AST_BUSY_AFTER_START");

endmodule

// File: rtl/segbuf_sweep.sv
module segbuf_sweep
    import segbuf_pkg::*;
#(
    parameter int N      = 8,
    parameter int TAG_W  = 12,
    parameter int DATA_W = 16,
    localparam int IDX_W = (N > 2) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              new_rules,
    input  logic              start,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              flush_ack,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_class,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_class,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              flush_req,
    output logic              hint_warn
);

    logic [HINT_W-1:0] hint;
    logic              unused_cmd_bits;
    hint_rule_t        rule;
    logic [IDX_W-1:0]  scan_idx;
    logic              scan_valid;
    logic              scan_class;
    logic              clr_en;
    logic              busy_w;

    assign hint            = cmd_word[HINT_LSB +: HINT_W];
    assign unused_cmd_bits = ^{cmd_word[CMD_W-1:HINT_LSB+HINT_W], cmd_word[HINT_LSB-1:0]};

    segbuf_hint_decode u_decode (
        .hint      (hint),
        .new_rules (new_rules),
        .rule      (rule)
    );

    segbuf_walk_fsm #(.N(N), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .rule       (rule),
        .flush_ack  (flush_ack),
        .scan_valid (scan_valid),
        .scan_class (scan_class),
        .scan_idx   (scan_idx),
        .clr_en     (clr_en),
        .busy       (busy_w),
        .done       (done),
        .flush_req  (flush_req),
        .hint_warn  (hint_warn)
    );

    segbuf_store #(.N(N), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock       (busy_w),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_valid   (wr_valid),
        .wr_class   (wr_class),
        .wr_tag     (wr_tag),
        .wr_data    (wr_data),
        .clr_en     (clr_en),
        .clr_idx    (scan_idx),
        .scan_idx   (scan_idx),
        .scan_valid (scan_valid),
        .scan_class (scan_class),
        .rd_idx     (rd_idx),
        .rd_valid   (rd_valid),
        .rd_class   (rd_class),
        .rd_tag     (rd_tag),
        .rd_data    (rd_data)
    );

    assign busy = busy_w;

    AST_IDLE_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !clr_en) // R10
        else $error("AST_IDLE_NO_CLEAR");

endmodule

// File: tb/segbuf_sweep_tb_top.sv
module segbuf_sweep_tb_top;

    localparam int N      = 8;
    localparam int TAG_W  = 12;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 3;

    typedef struct {
        int due;
        bit warn;
    } exp_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              new_rules = 1'b0;
    logic              start = 1'b0;
    logic [31:0]       cmd_word = '0;
    logic              flush_ack = 1'b0;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic              wr_valid = 1'b0;
    logic              wr_class = 1'b0;
    logic [TAG_W-1:0]  wr_tag = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic              rd_valid, rd_class;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              busy, done, flush_req, hint_warn;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit warn_seen = 0;
    bit finished = 0;
    exp_item_t exp_q[$];

    bit              m_v[N];
    bit              m_c[N];
    logic [TAG_W-1:0]  m_t[N];
    logic [DATA_W-1:0] m_d[N];

    segbuf_sweep #(.N(N), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .new_rules(new_rules), .start(start),
        .cmd_word(cmd_word), .flush_ack(flush_ack), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_class(wr_class),
        .wr_tag(wr_tag), .wr_data(wr_data), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_class(rd_class), .rd_tag(rd_tag),
        .rd_data(rd_data), .busy(busy), .done(done),
        .flush_req(flush_req), .hint_warn(hint_warn)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // monitor: pops expected completions as done pulses appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (hint_warn) warn_seen = 1;
                if (done) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R10 unexpected done", 1, 0);
                    end else begin
                        exp_item_t it;
                        it = exp_q.pop_front();
                        chk(cyc == it.due, "R9 done cycle", cyc, it.due);
                        chk(warn_seen == it.warn, "R5 warn", int'(warn_seen), int'(it.warn));
                        warn_seen = 0;
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    task automatic write_entry(input int i, input bit v, input bit c,
                               input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1; wr_idx = IDX_W'(i); wr_valid = v; wr_class = c; wr_tag = t; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        m_v[i] = v; m_c[i] = c; m_t[i] = t; m_d[i] = d;
        rd_idx = IDX_W'(i);
        #1;
        chk(rd_tag == t && rd_valid == v, "R12 read after write", int'(rd_tag), int'(t));
    endtask

    task automatic load_all(input bit all_valid);
        for (int i = 0; i < N; i++)
            write_entry(i, all_valid | i[1], i[0], TAG_W'(12'h100 + i), DATA_W'(16'hA000 + 3 * i));
    endtask

    task automatic check_all(input string req);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            rd_idx = IDX_W'(i);
            #1;
            chk(rd_valid == m_v[i], req, int'(rd_valid), int'(m_v[i]));
            chk(rd_class == m_c[i] && rd_tag == m_t[i] && rd_data == m_d[i],
                "R6 fields kept", int'(rd_tag), int'(m_t[i]));
        end
    endtask

    // driver: predicts the outcome from the requirements and issues the command
    task automatic run_cmd(input bit nr, input int hint, input bit ack_too, input bit poke_busy);
        int first;
        bit keep0, skip, warn;
        exp_item_t it;
        first = 1; keep0 = 0; skip = 0; warn = 0;
        if (nr) begin
            if (hint == 3) begin first = 0; keep0 = 1; end
            if (hint == 4) first = 0;
            if (hint == 7) skip = 1;
            if (hint == 5) warn = 1;
        end
        if (!skip)
            for (int i = first; i < N; i++)
                if (m_v[i] && !(keep0 && !m_c[i])) m_v[i] = 0;
        @(negedge clk);
        it.due = cyc + 1 + (skip ? 0 : N - first);
        it.warn = warn;
        exp_q.push_back(it);
        new_rules = nr;
        // R7: bits outside [23:21] all ones
        cmd_word = 32'hFF1F_FFFF | (32'(hint) << 21);
        start = 1;
        flush_ack = ack_too;
        @(negedge clk);
        start = 0;
        flush_ack = 0;
        cmd_word = '0;
        chk(flush_req == 1, "R8 flush set by command", int'(flush_req), 1);
        chk(busy == 1, "R10 busy after start", int'(busy), 1);
        if (poke_busy && !skip) begin
            start = 1; cmd_word = 32'(4) << 21; new_rules = 1;
            wr_en = 1; wr_idx = '0; wr_valid = 0; wr_class = 1;
            wr_tag = 12'hBAD; wr_data = 16'hDEAD;
            @(negedge clk);
            start = 0; wr_en = 0; cmd_word = '0;
        end
        for (int k = 0; k < 4 * N; k++) begin
            if (!busy) break;
            @(negedge clk);
        end
        chk(busy == 0, "R10 busy drops", int'(busy), 0);
        chk(exp_q.size() == 0, "R9 done seen", exp_q.size(), 0);
        chk(flush_req == 1, "R8 flush held", int'(flush_req), 1);
        flush_ack = 1;
        @(negedge clk);
        flush_ack = 0;
        chk(flush_req == 0, "R8 ack clears", int'(flush_req), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0, "R11 reset ctrl", int'(busy), 0);
        chk(flush_req == 0 && hint_warn == 0, "R11 reset flags", int'(flush_req), 0);
        for (int i = 0; i < N; i++) begin
            rd_idx = IDX_W'(i);
            #1;
            chk(rd_valid == 0, "R11 reset valid", int'(rd_valid), 0);
        end
        rst_n = 1;

        load_all(1); run_cmd(0, 0, 0, 0); check_all("R1 old hint0");
        load_all(1); run_cmd(0, 3, 0, 0); check_all("R1 old hint3");
        load_all(1); run_cmd(0, 7, 0, 0); check_all("R1 old hint7");
        load_all(1); run_cmd(1, 6, 0, 0); check_all("R1 new hint6");
        load_all(1); run_cmd(1, 1, 0, 0); check_all("R1 new hint1");
        load_all(1); run_cmd(1, 2, 0, 0); check_all("R1 new hint2");
        load_all(1); run_cmd(1, 4, 0, 0); check_all("R2 new hint4");
        load_all(1); run_cmd(1, 3, 0, 0); check_all("R3 new hint3");
        load_all(1); run_cmd(1, 7, 0, 0); check_all("R4 new hint7");
        load_all(1); run_cmd(1, 5, 0, 0); check_all("R5 new hint5");
        load_all(1); run_cmd(0, 5, 0, 0); check_all("R5 old hint5");
        load_all(0); run_cmd(1, 4, 0, 0); check_all("R6 invalid skipped");
        load_all(1); run_cmd(1, 0, 1, 0); check_all("R8 ack with start");
        load_all(1); run_cmd(0, 0, 0, 1); check_all("R10 poke while busy");
        load_all(0); run_cmd(1, 3, 0, 0); check_all("R3 mixed valid");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R10 no extra done", exp_q.size(), 0);
        finish_run();
    end

endmodule